// File: doc/BRIEF.md
# Eight-Bit ALU with Zero and Carry Flags

This block is the arithmetic and logic datapath of a small accumulator-style processor. Two 8-bit operands and a 3-bit operation code go in. A combinational 8-bit result comes out. Two flag bits, zero and carry, are kept in registers. The flags change only on a clock edge where the flag-load strobe is high. Control logic outside the block uses the carry flag for conditional branches. The rotate-right operation also feeds the carry flag back in as data.

Eight operations are available: subtract, add, bitwise AND, decrement, clear, circular rotate left, rotate right through carry, and pass-through of the second operand. Operand routing, the register file and the sequencing of the select lines belong to the surrounding processor and are not part of this block.

Top module: `flag_alu8`

## Requirements
- R1: With op_sel = 0 (subtract), result = (a - b) mod 256, and a flag load sets carry exactly when a < b unsigned (borrow).
- R2: With op_sel = 1 (add), result = (a + b) mod 256, and a flag load sets carry exactly when a + b > 255. 0x11 + 0xFF sets carry; 0x22 + 0x11 clears it.
- R3: With op_sel = 2 (AND), result = a & b, and a flag load leaves carry unchanged.
- R4: With op_sel = 3 (decrement), result = (a - 1) mod 256, and a flag load sets carry exactly when a = 0x00 (wrap to 0xFF).
- R5: With op_sel = 4 (clear), result = 0x00 for any a and b, and a flag load leaves carry unchanged.
- R6: With op_sel = 5 (rotate left), result = {a[6:0], a[7]}. The carry flag has no effect on the result, and a flag load leaves carry unchanged.
- R7: With op_sel = 6 (rotate right through carry), result = {carry_f, a[7:1]}, and a flag load sets carry to a[0].
- R8: With op_sel = 7 (pass), result = b, and a flag load leaves carry unchanged.
- R9: On a flag load, zero_f becomes 1 exactly when result is 0x00. For example, subtracting a value from itself sets it.
- R10: When flag_ld is low at a rising edge, zero_f and carry_f keep their values.
- R11: rst_n low at a rising edge clears zero_f and carry_f. The reset is synchronous and active low, and it takes priority over flag_ld.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| op_sel | input | 3 | Operation code (0 sub, 1 add, 2 and, 3 dec, 4 clr, 5 rol, 6 rrc, 7 pass) |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| flag_ld | input | 1 | Load the zero and carry flags at the next rising edge |
| result | output | 8 | Combinational result |
| zero_f | output | 1 | Registered zero flag |
| carry_f | output | 1 | Registered carry/borrow flag |

## Verification
The bench sweeps every operation over all 65,536 operand pairs and compares each result against a value computed in the bench. This catches a swapped operand in subtract, a rotate that brings in carry instead of bit 7, and a clear or pass that still depends on the wrong operand. A clocked pass then walks all 256 values of a for every operation with a mix of loading and holding cycles, while the bench tracks its own copy of the flags. That pass catches:
- a borrow with inverted polarity;
- a decrement that fails to report the wrap from 0x00;
- a logic operation that clobbers carry;
- a rotate-right that loses the old carry or the old bit 0;
- flags that move while flag_ld is low.

The add cases 0x11 + 0xFF and 0x22 + 0x11, and a self-subtract, are checked directly. So is a reset applied while both flags are set.

// File: rtl/alu8_pkg.sv
// Shared operation codes for the 8-bit flag ALU.
package alu8_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SUB  = 3'd0,
        OP_ADD  = 3'd1,
        OP_AND  = 3'd2,
        OP_DEC  = 3'd3,
        OP_CLR  = 3'd4,
        OP_ROL  = 3'd5,
        OP_RRC  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;
endpackage

// File: rtl/alu_arith.sv
// Arithmetic slice: add, subtract and decrement with a carry/borrow out.
// Assumes op is one of the arithmetic codes when its outputs are selected;
// other codes produce zero here.
module alu_arith
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] ext;

    // One extended-width operation; the top bit is carry (add) or borrow (sub, dec).
    always_comb begin
        case (op)
            OP_ADD:  ext = {1'b0, a} + {1'b0, b};
            OP_SUB:  ext = {1'b0, a} - {1'b0, b};
            OP_DEC:  ext = {1'b0, a} - EXT_W'(1);
            default: ext = '0;
        endcase
        res  = ext[WIDTH-1:0];
        cout = ext[WIDTH];
    end

    // R4: a decrement borrow can only come with an all-ones result.
    always_comb begin
        if (op == OP_DEC && cout)
            a_r4_dec_wrap_all_ones: assert (res == '1);
    end
endmodule

// File: rtl/alu_logic.sv
// Logic and shift slice: AND, clear, circular rotate left, rotate right
// through carry, and pass-through. The carry out equals cin except for the
// right rotate, where it takes the bit shifted out.
module alu_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    // Select the bitwise or shifted value; only the right rotate touches carry.
    always_comb begin
        cout = cin;
        case (op)
            OP_AND:  res = a & b;
            OP_CLR:  res = '0;
            OP_ROL:  res = {a[WIDTH-2:0], a[WIDTH-1]};
            OP_RRC: begin
                res  = {cin, a[WIDTH-1:1]};
                cout = a[0];
            end
            OP_PASS: res = b;
            default: res = '0;
        endcase
    end

    // R6 and R7: rotates keep the number of ones across the rotated path.
    always_comb begin
        if (op == OP_ROL)
            a_r6_rol_keeps_ones: assert ($countones(res) == $countones(a));
        if (op == OP_RRC)
            a_r7_rrc_keeps_ones: assert ($countones(res) + int'(cout) == $countones(a) + int'(cin));
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Zero and carry flag register. Loads on a rising edge while ld is high.
// A synchronous active-low reset clears both flags and wins over ld.
module alu_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ld,
    input  logic z_in,
    input  logic c_in,
    output logic z_q,
    output logic c_q
);
    // Flag storage: reset first, then a conditional load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else if (ld) begin
            z_q <= z_in;
            c_q <= c_in;
        end
    end

    // R11: a reset edge leaves both flags clear.
    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!z_q && !c_q));

    // R10: without a load, the flags hold.
    a_r10_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable({z_q, c_q}));
endmodule

// File: rtl/flag_alu8.sv
// Top of the 8-bit flag ALU. It routes the operation to the arithmetic or
// logic slice, forms the zero indication from the selected result, and keeps
// the flags registered. Assumes op_sel and the operands are stable around the
// clock edge when flag_ld is high.
module flag_alu8
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             flag_ld,
    output logic [WIDTH-1:0] result,
    output logic             zero_f,
    output logic             carry_f
);
    alu_op_e          op;
    logic             is_arith;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic             arith_c;
    logic             logic_c;
    logic             c_next;
    logic             z_next;

    assign op = alu_op_e'(op_sel);

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .op   (op),
        .a    (a),
        .b    (b),
        .res  (arith_res),
        .cout (arith_c)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op   (op),
        .a    (a),
        .b    (b),
        .cin  (carry_f),
        .res  (logic_res),
        .cout (logic_c)
    );

    // Pick the slice that owns this operation and derive the next flags.
    always_comb begin
        is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_DEC);
        result   = is_arith ? arith_res : logic_res;
        c_next   = is_arith ? arith_c : logic_c;
        z_next   = (result == '0);
    end

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (flag_ld),
        .z_in  (z_next),
        .c_in  (c_next),
        .z_q   (zero_f),
        .c_q   (carry_f)
    );

    // R9: a loaded zero result shows as a set zero flag.
    a_r9_zero_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ld && result == '0) |=> zero_f);

    // R7: a loaded right rotate moves the old bit 0 into carry.
    a_r7_rrc_carry_from_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ld && op == OP_RRC) |=> (carry_f == $past(a[0])));

    // R5: clear gives an all-zero result.
    always_comb begin
        if (op == OP_CLR)
            a_r5_clear_zero: assert (result == '0);
    end
endmodule

// File: tb/flag_alu8_tb.sv
module flag_alu8_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] op_sel;
    logic [7:0] a;
    logic [7:0] b;
    logic       flag_ld;
    logic [7:0] result;
    logic       zero_f;
    logic       carry_f;

    int compared = 0;
    int mismatched = 0;
    bit ec = 1'b0;
    bit ez = 1'b0;

    string req_of_op [8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8"};

    always #4 clk = ~clk;

    flag_alu8 u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_sel  (op_sel),
        .a       (a),
        .b       (b),
        .flag_ld (flag_ld),
        .result  (result),
        .zero_f  (zero_f),
        .carry_f (carry_f)
    );

    // Reference model: returns {carry, result} from the requirement text.
    function automatic logic [8:0] model(int op, int x, int y, bit c);
        int  r;
        bit  cc;
        cc = c;
        case (op)
            0: begin r = (x - y) & 255; cc = (x < y); end
            1: begin r = (x + y) & 255; cc = ((x + y) > 255); end
            2: r = x & y;
            3: begin r = (x + 255) & 255; cc = (x == 0); end
            4: r = 0;
            5: r = ((x << 1) | (x >> 7)) & 255;
            6: begin r = (x >> 1) | (int'(c) << 7); cc = x[0]; end
            default: r = y;
        endcase
        return {cc, 8'(r)};
    endfunction

    task automatic check(string req, int act, int exp, string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one clocked operation and check the result, then the flags.
    task automatic step(int op, int x, int y, bit ld);
        logic [8:0] m;
        @(negedge clk);
        op_sel = 3'(op); a = 8'(x); b = 8'(y); flag_ld = ld;
        m = model(op, x, y, ec);
        #1;
        check(req_of_op[op], int'(result), int'(m[7:0]), "result");
        @(posedge clk);
        #1;
        if (ld) begin
            ec = m[8];
            ez = (m[7:0] == 8'h00);
            check("R9", int'(zero_f), int'(ez), "zero flag");
            check(req_of_op[op], int'(carry_f), int'(ec), "carry flag");
        end else begin
            check("R10", int'({zero_f, carry_f}), int'({ez, ec}), "held flags");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_sel = 3'd0; a = 8'h00; b = 8'h00; flag_ld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R11", int'({zero_f, carry_f}), 0, "flags after reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive combinational sweep with flags held at zero (R1..R8).
        for (int op = 0; op < 8; op++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    logic [8:0] m;
                    op_sel = 3'(op); a = 8'(x); b = 8'(y);
                    m = model(op, x, y, 1'b0);
                    #1;
                    check(req_of_op[op], int'(result), int'(m[7:0]), "sweep result");
                end
            end
        end

        // Named corner cases: R2 carry on 0x11+0xFF, none on 0x22+0x11; R9 self-subtract.
        step(1, 8'h11, 8'hFF, 1'b1);
        check("R2", int'(carry_f), 1, "0x11+0xFF carry");
        step(1, 8'h22, 8'h11, 1'b1);
        check("R2", int'(carry_f), 0, "0x22+0x11 carry");
        step(0, 8'h5A, 8'h5A, 1'b1);
        check("R9", int'(zero_f), 1, "self-subtract zero");
        step(3, 8'h00, 8'h00, 1'b1);
        check("R4", int'({carry_f, result}), 9'h1FF, "decrement wrap");

        // Flag walk over every operation, mixing loads and holds (R10).
        for (int op = 0; op < 8; op++) begin
            for (int x = 0; x < 256; x++) begin
                step(op, x, (x * 37 + 11) & 255, (x % 5) != 0);
            end
        end

        // R6: rotate left ignores a set carry.
        step(0, 8'h00, 8'h01, 1'b1);
        step(5, 8'h81, 8'h00, 1'b0);
        check("R6", int'(result), 8'h03, "rol with carry set");

        // R11: reset wins over a load with both flags set.
        step(4, 8'hFF, 8'hFF, 1'b1);
        check("R5", int'({zero_f, carry_f}), 3, "clear keeps carry, sets zero");
        @(negedge clk);
        rst_n = 1'b0; op_sel = 3'd1; a = 8'hFF; b = 8'h01; flag_ld = 1'b1;
        @(posedge clk);
        #1;
        check("R11", int'({zero_f, carry_f}), 0, "reset over load");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule